// File: doc/BRIEF.md
# Mode-Selectable Lower-Part Approximate Adder

This block is a purely combinational unsigned adder whose word is divided in two. The upper part, from bit `APPROX_BITS` to the top, is always summed exactly and yields the carry-out. The lower `APPROX_BITS` bits can be formed by one of several cheap approximations. A 3-bit mode input selects the approximation for each operation. The mode also decides whether the lower part passes a carry into the upper part.

Callers that can tolerate small errors in the low-order bits pick an approximate mode to trade accuracy for a shorter carry path. A reference-grade result is always available through the exact mode. The split width is fixed when the block is built. The upper adder can be built as an explicit ripple chain or left to the synthesis operator.

Top module: `approx_lsb_adder`

## Requirements
- R1: With mode code 0 (exact), `{cout, sum}` equals the full unsigned sum `a + b`, with no carry-in.
- R2: With mode code 1 (truncate), the low `APPROX_BITS` sum bits are 0 and no carry enters the upper part.
- R3: With mode code 2 (copy), the low `APPROX_BITS` sum bits equal the low bits of `a`, and no carry enters the upper part.
- R4: With mode code 3 (shifted copy), sum bit 0 is 1 and sum bit i equals `a` bit i-1 for 1 <= i < `APPROX_BITS`. No carry enters the upper part.
- R5: With mode code 4 (OR), each low sum bit is the OR of the operand bits. The carry into bit `APPROX_BITS` is `a[APPROX_BITS-1] & b[APPROX_BITS-1]`.
- R6: With mode code 5 (OR with half-adder), low bits 0 to `APPROX_BITS-2` are the OR of the operand bits and bit `APPROX_BITS-1` is their XOR. The carry into the upper part is the AND of the operand bits at `APPROX_BITS-1`.
- R7: With mode code 6 (saturating), the low bits are scanned from the top low bit downward. At the highest position where both operand bits are 1, that bit and every bit below it are 1. Above that position, each bit is the XOR of the operand bits. No carry enters the upper part.
- R8: Mode code 7 gives the same result as the exact mode.
- R9: In every approximate mode, `{cout, sum[WIDTH-1:APPROX_BITS]}` equals the exact sum of the upper operand bits plus the mode's carry into the upper part.
- R10: The parameters must satisfy 2 <= `APPROX_BITS` < `WIDTH`; other values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| mode | input | 3 | Lower-part scheme select (0 exact, 1 truncate, 2 copy, 3 shifted copy, 4 OR, 5 OR+half-adder, 6 saturating, 7 exact) |
| sum | output | WIDTH | Approximate or exact sum |
| cout | output | 1 | Carry out of the upper part |

## Verification
The checker relies on the operands and the mode being settled, known values when it evaluates. It skips any evaluation in which an input still holds unknown bits. This covers the time before the bench first drives the ports. The bench sets all three inputs together in one step away from the sampling point, so every comparison sees a consistent input set. Random operands are mixed with directed patterns that put carry chains across the split, set both top low bits, and use all-ones and all-zeros words.

// File: rtl/apx_pkg.sv
package apx_pkg;
   typedef enum logic [2:0] {
      APX_EXACT  = 3'd0,
      APX_TRUNC  = 3'd1,
      APX_COPY   = 3'd2,
      APX_SHCOPY = 3'd3,
      APX_OR     = 3'd4,
      APX_ORHA   = 3'd5,
      APX_SAT    = 3'd6,
      APX_RSVD   = 3'd7
   } apx_mode_e;

   localparam int ARCH_RIPPLE   = 0;
   localparam int ARCH_OPERATOR = 1;
endpackage

// File: rtl/apx_lower.sv
// Lower approximate slice: forms the low bits and the carry handed upward.
module apx_lower
   import apx_pkg::*;
#(
   parameter int K = 4
) (
   input  logic [K-1:0] a_lo,
   input  logic [K-1:0] b_lo,
   input  apx_mode_e    mode,
   output logic [K-1:0] lo_sum,
   output logic         lo_carry
);
   logic [K:0]   exact_lo;
   logic [K-1:0] or_bits;
   logic [K-1:0] xor_bits;
   logic [K-1:0] both_bits;
   logic [K-1:0] sat_fill;
   logic [K-1:0] sh_bits;
   logic [K-1:0] orha_bits;

   assign exact_lo  = {1'b0, a_lo} + {1'b0, b_lo};
   assign or_bits   = a_lo | b_lo;
   assign xor_bits  = a_lo ^ b_lo;
   assign both_bits = a_lo & b_lo;
   assign sh_bits   = {a_lo[K-2:0], 1'b1};
   assign orha_bits = {xor_bits[K-1], or_bits[K-2:0]};

   // Saturating fill: a bit is forced high once any position at or above
   // it has both operand bits set.
   assign sat_fill[K-1] = both_bits[K-1];
   for (genvar j = K - 2; j >= 0; j--) begin : g_fill
      assign sat_fill[j] = sat_fill[j+1] | both_bits[j];
   end

   always_comb begin
      lo_sum   = exact_lo[K-1:0];
      lo_carry = exact_lo[K];
      unique case (mode)
         APX_TRUNC: begin
            lo_sum   = '0;
            lo_carry = 1'b0;
         end
         APX_COPY: begin
            lo_sum   = a_lo;
            lo_carry = 1'b0;
         end
         APX_SHCOPY: begin
            lo_sum   = sh_bits;
            lo_carry = 1'b0;
         end
         APX_OR: begin
            lo_sum   = or_bits;
            lo_carry = both_bits[K-1];
         end
         APX_ORHA: begin
            lo_sum   = orha_bits;
            lo_carry = both_bits[K-1];
         end
         APX_SAT: begin
            lo_sum   = xor_bits | sat_fill;
            lo_carry = 1'b0;
         end
         default: begin
            lo_sum   = exact_lo[K-1:0];
            lo_carry = exact_lo[K];
         end
      endcase
   end
endmodule

// File: rtl/apx_upper.sv
// Exact upper adder; ARCH picks an explicit ripple chain or the operator.
module apx_upper
   import apx_pkg::*;
#(
   parameter int N    = 28,
   parameter int ARCH = ARCH_RIPPLE
) (
   input  logic [N-1:0] a_hi,
   input  logic [N-1:0] b_hi,
   input  logic         cin,
   output logic [N-1:0] sum_hi,
   output logic         cout
);
   if (ARCH == ARCH_RIPPLE) begin : g_ripple
      logic [N:0] c;
      assign c[0] = cin;
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign sum_hi[i] = a_hi[i] ^ b_hi[i] ^ c[i];
         assign c[i+1]    = (a_hi[i] & b_hi[i]) | (c[i] & (a_hi[i] ^ b_hi[i]));
      end
      assign cout = c[N];
   end else begin : g_operator
      logic [N:0] full;
      assign full   = {1'b0, a_hi} + {1'b0, b_hi} + {{N{1'b0}}, cin};
      assign sum_hi = full[N-1:0];
      assign cout   = full[N];
   end
endmodule

// File: rtl/approx_lsb_adder.sv
module approx_lsb_adder
   import apx_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int APPROX_BITS = 4,
   parameter int UPPER_ARCH  = ARCH_RIPPLE
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [2:0]       mode,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int UPPER_BITS = WIDTH - APPROX_BITS;

   // R10: parameter range
   if (APPROX_BITS < 2 || APPROX_BITS >= WIDTH) begin : g_bad_split
      $error("approx_lsb_adder: APPROX_BITS must be in [2, WIDTH-1]");
   end
   if (UPPER_ARCH != ARCH_RIPPLE && UPPER_ARCH != ARCH_OPERATOR) begin : g_bad_arch
      $error("approx_lsb_adder: unknown UPPER_ARCH");
   end

   apx_mode_e mode_e;
   logic      lo_carry;

   assign mode_e = apx_mode_e'(mode);

   apx_lower #(.K(APPROX_BITS)) i_lower (
      .a_lo     (a[APPROX_BITS-1:0]),
      .b_lo     (b[APPROX_BITS-1:0]),
      .mode     (mode_e),
      .lo_sum   (sum[APPROX_BITS-1:0]),
      .lo_carry (lo_carry)
   );

   apx_upper #(.N(UPPER_BITS), .ARCH(UPPER_ARCH)) i_upper (
      .a_hi   (a[WIDTH-1:APPROX_BITS]),
      .b_hi   (b[WIDTH-1:APPROX_BITS]),
      .cin    (lo_carry),
      .sum_hi (sum[WIDTH-1:APPROX_BITS]),
      .cout   (cout)
   );
endmodule

// File: rtl/apx_checker.sv
module apx_checker #(
   parameter int WIDTH       = 32,
   parameter int APPROX_BITS = 4
) (
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic [2:0]       mode,
   input logic [WIDTH-1:0] sum,
   input logic             cout
);
   localparam int K = APPROX_BITS;
   localparam int U = WIDTH - APPROX_BITS;

   logic [WIDTH:0] full_ref;
   logic [U:0]     hi_plain;
   logic [U:0]     hi_carry;
   logic           known;

   assign full_ref = {1'b0, a} + {1'b0, b};
   assign hi_plain = {1'b0, a[WIDTH-1:K]} + {1'b0, b[WIDTH-1:K]};
   assign hi_carry = hi_plain + {{U{1'b0}}, 1'b1};
   assign known    = !$isunknown({a, b, mode});

   always_comb begin
      if (known) begin
         if (mode == 3'd0 || mode == 3'd7) begin
            AST_EXACT_SUM: assert ({cout, sum} == full_ref); // R1
         end
         if (mode == 3'd1) begin
            AST_TRUNC_LOW_ZERO: assert (sum[K-1:0] == '0); // R2
         end
         if (mode == 3'd2) begin
            AST_COPY_LOW_A: assert (sum[K-1:0] == a[K-1:0]); // R3
         end
         if (mode == 3'd3) begin
            AST_SHCOPY_LOW: assert (sum[K-1:0] == {a[K-2:0], 1'b1}); // R4
         end
         if (mode == 3'd4) begin
            AST_OR_LOW: assert (sum[K-1:0] == (a[K-1:0] | b[K-1:0])); // R5
         end
         if (mode == 3'd5) begin
            AST_ORHA_TOP_XOR: assert (sum[K-1] == (a[K-1] ^ b[K-1])); // R6
         end
         if (mode == 3'd6 && a[K-1] && b[K-1]) begin
            AST_SAT_ALL_ONES: assert (sum[K-1:0] == '1); // R7
         end
         if ((mode == 3'd4 || mode == 3'd5) && a[K-1] && b[K-1]) begin
            AST_UPPER_WITH_CARRY: assert ({cout, sum[WIDTH-1:K]} == hi_carry); // R9
         end
         if (mode == 3'd1 || mode == 3'd2 || mode == 3'd3 || mode == 3'd6) begin
            AST_UPPER_NO_CARRY: assert ({cout, sum[WIDTH-1:K]} == hi_plain); // R9
         end
      end
   end
endmodule

bind approx_lsb_adder apx_checker #(
   .WIDTH       (WIDTH),
   .APPROX_BITS (APPROX_BITS)
) i_apx_checker (
   .a    (a),
   .b    (b),
   .mode (mode),
   .sum  (sum),
   .cout (cout)
);

// File: tb/test_approx_lsb_adder.sv
`timescale 1ns/1ps
module test_approx_lsb_adder;
   localparam int W = 32;
   localparam int K = 4;
   localparam int WATCHDOG_CYCLES = 100000;

   logic         clk = 1'b0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic [2:0]   mode = 3'd0;
   logic [W-1:0] sum;
   logic         cout;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   approx_lsb_adder #(.WIDTH(W), .APPROX_BITS(K)) i_approx_lsb_adder (
      .a(a), .b(b), .mode(mode), .sum(sum), .cout(cout)
   );

   function automatic string req_of(input logic [2:0] m);
      case (m)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         3'd5: return "R6";
         3'd6: return "R7";
         default: return "R8";
      endcase
   endfunction

   // Behavioural model: returns {carry, sum} as a W+1 bit value.
   function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                        input logic [2:0] m);
      longint unsigned hx, hy, lo, cin, res;
      bit found;
      hx = longint'(x) >> K;
      hy = longint'(y) >> K;
      lo = 0;
      cin = 0;
      if (m == 3'd0 || m == 3'd7) begin
         res = longint'(x) + longint'(y);
         return res[W:0];
      end
      case (m)
         3'd2: for (int i = 0; i < K; i++) lo[i] = x[i];
         3'd3: begin
            lo[0] = 1'b1;
            for (int i = 1; i < K; i++) lo[i] = x[i-1];
         end
         3'd4: begin
            for (int i = 0; i < K; i++) lo[i] = x[i] | y[i];
            cin = longint'(x[K-1] & y[K-1]);
         end
         3'd5: begin
            for (int i = 0; i < K - 1; i++) lo[i] = x[i] | y[i];
            lo[K-1] = x[K-1] ^ y[K-1];
            cin = longint'(x[K-1] & y[K-1]);
         end
         3'd6: begin
            found = 1'b0;
            for (int i = K - 1; i >= 0; i--) begin
               if (x[i] && y[i]) found = 1'b1;
               lo[i] = found ? 1'b1 : (x[i] ^ y[i]);
            end
         end
         default: lo = 0;
      endcase
      res = ((hx + hy + cin) << K) | lo;
      return res[W:0];
   endfunction

   task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] m);
      logic [W:0] exp_v;
      logic [W:0] got;
      @(posedge clk);
      a = x;
      b = y;
      mode = m;
      @(negedge clk);
      exp_v = model(x, y, m);
      got = {cout, sum};
      total++;
      if (got !== exp_v) begin
         bad++;
         $display("FAIL %s mode=%0d a=%h b=%h actual=%h expected=%h",
                  req_of(m), m, x, y, got, exp_v);
      end
      // R9: upper part and carry-out in approximate modes
      if (m != 3'd0 && m != 3'd7) begin
         total++;
         if (got[W:K] !== exp_v[W:K]) begin
            bad++;
            $display("FAIL R9 mode=%0d a=%h b=%h actual=%h expected=%h",
                     m, x, y, got[W:K], exp_v[W:K]);
         end
      end
   endtask

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // Idle state: exact mode, zero operands gives zero (R1)
      apply('0, '0, 3'd0);
      for (int m = 0; m < 8; m++) begin
         // Carry chain from the low part across the split
         apply(32'h0000_000F, 32'h0000_0001, 3'(m));
         // Both top low bits set: carry injection for R5/R6, saturation for R7
         apply(32'h1234_5678, 32'h0000_000C, 3'(m));
         // All ones: full chain and carry-out
         apply('1, '1, 3'(m));
         apply('1, 32'h0000_0001, 3'(m));
         // No position with both bits set: R7 gives plain XOR
         apply(32'hAAAA_AAA5, 32'h5555_555A, 3'(m));
         // Only bit 0 shared: R7 fills only bit 0
         apply(32'h0000_0003, 32'h0000_0005, 3'(m));
         for (int r = 0; r < 300; r++) apply($urandom, $urandom, 3'(m));
      end
      // Code 7 must match code 0 on the same operands (R8)
      for (int r = 0; r < 50; r++) begin
         logic [W-1:0] x;
         logic [W-1:0] y;
         logic [W:0]   g0;
         x = $urandom;
         y = $urandom;
         apply(x, y, 3'd0);
         g0 = {cout, sum};
         apply(x, y, 3'd7);
         total++;
         if ({cout, sum} !== g0) begin
            bad++;
            $display("FAIL R8 actual=%h expected=%h", {cout, sum}, g0);
         end
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule